// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps a small store of recent virtual-page to physical-page translations in front of a page-table walker. A requester offers a virtual page number, a page offset and a load/store flag. The block looks the page up in a set-associative array. On a usable match it returns the physical address, which is the cached physical page number joined to the unchanged offset, together with the page's permission flags. On a miss it asks the walker for the leaf entry, writes the returned entry into the array and retries the lookup. If the walker reports a fault, nothing is written and the requester gets a fault response.

Coherence is kept in hardware in two ways. A pulse on `flush`, raised whenever the page-table base register is written, clears every entry. An invalidate command removes the entry that holds one given virtual page number. A store to a page whose cached dirty flag is clear is handled as a miss, so the walker can set the dirty flag in memory and return the updated entry. The walker must return a set dirty flag for a walk caused by a store.

The request, response, walk-request and walk-response paths are valid/ready channels. A beat moves on a clock edge where both valid and ready are high. The block accepts one request at a time and holds `req_ready` low until the response has been taken. `resp_valid` and `walk_req_valid` stay high, with their payload unchanged, until the other side takes them. `flush` and `inv_valid` are plain control pins that act in any cycle.

Top module: `tlb_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `walk_req_valid` are 0, and no entry is valid, so the first lookup of any page starts a walk.
- R2: A lookup that hits raises `resp_valid` one cycle after the request is accepted, with `resp_fault`=0, `resp_paddr`={cached page number, request offset}, and `resp_perm` the cached flags packed as bit3=dirty, bit2=read, bit1=write, bit0=execute. No walk is started.
- R3: A lookup that misses raises `walk_req_valid` one cycle after acceptance, with `walk_vpn` equal to the requested page. Both are held until `walk_req_ready` is seen.
- R4: A walk response without a fault installs the entry and retries the lookup, which then answers like a hit. Later lookups of that page hit without a walk.
- R5: A walk response with a fault installs nothing. The response carries `resp_fault`=1, and the next lookup of the same page walks again.
- R6: A `flush` pulse clears every entry, so every page cached before it misses afterwards.
- R7: An invalidate (`inv_valid` with `inv_vpn`) removes only the entry for that page. Other cached pages still hit.
- R8: A store that matches an entry whose dirty flag is 0 is handled as a miss and walks. The refreshed entry replaces the old one in its way, and a second store then hits.
- R9: Each set is 4-way and replaces its least recently used entry. Both hits and installs count as use, and an invalid way is chosen before any valid one.
- R10: If `flush` or `inv_valid` is high in the cycle a non-faulting walk response is taken, the fill is dropped and the retried lookup walks again.
- R11: While `resp_ready` is low, `resp_valid`, `resp_paddr`, `resp_perm` and `resp_fault` hold steady, and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vpn | input | 20 | Virtual page number of the request |
| req_offset | input | 12 | Byte offset within the page |
| req_store | input | 1 | 1 for a store, 0 for a load |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Requester takes the response |
| resp_fault | output | 1 | The walk reported a fault |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_perm | output | 4 | Flags {dirty, read, write, execute} |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_ready | input | 1 | Walker takes the walk request |
| walk_vpn | output | 20 | Page to walk |
| walk_rsp_valid | input | 1 | Walker returns a result |
| walk_rsp_ready | output | 1 | Block waiting for the walk result |
| walk_rsp_fault | input | 1 | The walk failed |
| walk_rsp_ppn | input | 20 | Physical page number of the leaf entry |
| walk_rsp_perm | input | 4 | Leaf flags {dirty, read, write, execute} |
| flush | input | 1 | Clear all entries (base register written) |
| inv_valid | input | 1 | Invalidate one entry |
| inv_vpn | input | 20 | Page to invalidate |

## Verification
A hit response is due exactly one cycle after the accepting edge. The bench notes the cycle of acceptance and checks that gap on every lookup that is expected to hit. Misses and faults take a variable number of cycles, so they are checked by the number of walks the bench walker saw and by the returned contents, never by a fixed delay. Outputs are sampled just after the falling edge, and a response is compared only on the cycle it is actually taken, so back-pressure windows never count twice.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic d;
    logic r;
    logic w;
    logic x;
  } perm_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_WREQ  = 3'd2,
    ST_WWAIT = 3'd3,
    ST_RESP  = 3'd4
  } tlb_state_e;
endpackage

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int WAYS  = 4,
  localparam int WW   = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_en,
  input  logic [WW-1:0]   touch_way,
  input  logic [WAYS-1:0] valid_i,
  output logic [WW-1:0]   victim_o
);
  logic [WW-1:0] age_q [WAYS];
  logic [WAYS-1:0] age_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WW'(i) == touch_way) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_way]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    victim_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid_i[i] && !found) begin
        victim_o = WW'(i);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age_q[i] == WW'(WAYS - 1)) victim_o = WW'(i);
      end
    end
  end

  always_comb begin
    age_seen = '0;
    for (int i = 0; i < WAYS; i++) age_seen[age_q[i]] = 1'b1;
  end

  AST_LRU_AGES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    age_seen == {WAYS{1'b1}}); // R9
endmodule

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20,
  localparam int IW   = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             inv_en_i,
  input  logic [IW-1:0]    inv_idx_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [3:0]       wr_perm_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [PPN_W-1:0] rd_ppn_o,
  output logic [3:0]       rd_perm_o
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  logic [3:0]       perm_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (inv_en_i && valid_q[inv_idx_i] && tag_q[inv_idx_i] == inv_tag_i)
        valid_q[inv_idx_i] <= 1'b0;
      if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      ppn_q[wr_idx_i]  <= wr_ppn_i;
      perm_q[wr_idx_i] <= wr_perm_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_ppn_o   = ppn_q[rd_idx_i];
  assign rd_perm_o  = perm_q[rd_idx_i];

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0)); // R6
  AST_FILL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (!flush_i && !inv_en_i)); // R10
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int IW    = $clog2(SETS),
  localparam int WW    = $clog2(WAYS),
  localparam int TAG_W = VPN_W - IW,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_offset,
  input  logic             req_store,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [3:0]       resp_perm,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_rsp_valid,
  output logic             walk_rsp_ready,
  input  logic             walk_rsp_fault,
  input  logic [PPN_W-1:0] walk_rsp_ppn,
  input  logic [3:0]       walk_rsp_perm,
  input  logic             flush,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn
);
  import tlb_pkg::*;

  tlb_state_e       state_q;
  logic [VPN_W-1:0] cur_vpn_q;
  logic [OFF_W-1:0] cur_off_q;
  logic             cur_store_q;
  logic [WW-1:0]    fill_way_q;

  logic [IW-1:0]    cur_idx;
  logic [TAG_W-1:0] cur_tag;
  assign cur_idx = cur_vpn_q[IW-1:0];
  assign cur_tag = cur_vpn_q[VPN_W-1:IW];

  logic [WAYS-1:0]  rd_valid;
  logic [TAG_W-1:0] rd_tag  [WAYS];
  logic [PPN_W-1:0] rd_ppn  [WAYS];
  logic [3:0]       rd_perm [WAYS];
  logic [WAYS-1:0]  match;
  logic             any_match;
  logic [WW-1:0]    match_way;
  logic [PPN_W-1:0] hit_ppn;
  perm_t            hit_perm;
  logic             hit_ok;
  logic             fill_fire;
  logic             lru_touch;
  logic [WW-1:0]    lru_way;
  logic [WW-1:0]    victims [SETS];
  logic [WW-1:0]    victim;

  // Way arrays
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_store #(.SETS(SETS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush),
      .inv_en_i  (inv_valid),
      .inv_idx_i (inv_vpn[IW-1:0]),
      .inv_tag_i (inv_vpn[VPN_W-1:IW]),
      .wr_en_i   (fill_fire && (fill_way_q == WW'(w))),
      .wr_idx_i  (cur_idx),
      .wr_tag_i  (cur_tag),
      .wr_ppn_i  (walk_rsp_ppn),
      .wr_perm_i (walk_rsp_perm),
      .rd_idx_i  (cur_idx),
      .rd_valid_o(rd_valid[w]),
      .rd_tag_o  (rd_tag[w]),
      .rd_ppn_o  (rd_ppn[w]),
      .rd_perm_o (rd_perm[w])
    );
    assign match[w] = rd_valid[w] && (rd_tag[w] == cur_tag);
  end

  // Replacement state, one per set
  for (genvar s = 0; s < SETS; s++) begin : g_set
    tlb_lru #(.WAYS(WAYS)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .touch_en (lru_touch && (cur_idx == IW'(s))),
      .touch_way(lru_way),
      .valid_i  (rd_valid),
      .victim_o (victims[s])
    );
  end
  assign victim = victims[cur_idx];

  always_comb begin
    any_match = 1'b0;
    match_way = '0;
    hit_ppn   = '0;
    hit_perm  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        any_match = 1'b1;
        match_way = WW'(w);
        hit_ppn   = rd_ppn[w];
        hit_perm  = perm_t'(rd_perm[w]);
      end
    end
  end

  assign hit_ok    = any_match && (!cur_store_q || hit_perm.d);
  assign fill_fire = (state_q == ST_WWAIT) && walk_rsp_valid && !walk_rsp_fault
                     && !flush && !inv_valid;
  assign lru_touch = ((state_q == ST_LOOK) && hit_ok) || fill_fire;
  assign lru_way   = fill_fire ? fill_way_q : match_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_vpn_q   <= '0;
      cur_off_q   <= '0;
      cur_store_q <= 1'b0;
      fill_way_q  <= '0;
      resp_fault  <= 1'b0;
      resp_paddr  <= '0;
      resp_perm   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          cur_vpn_q   <= req_vpn;
          cur_off_q   <= req_offset;
          cur_store_q <= req_store;
          state_q     <= ST_LOOK;
        end
        ST_LOOK: if (hit_ok) begin
          resp_fault <= 1'b0;
          resp_paddr <= {hit_ppn, cur_off_q};
          resp_perm  <= hit_perm;
          state_q    <= ST_RESP;
        end else begin
          fill_way_q <= any_match ? match_way : victim;
          state_q    <= ST_WREQ;
        end
        ST_WREQ: if (walk_req_ready) state_q <= ST_WWAIT;
        ST_WWAIT: if (walk_rsp_valid) begin
          if (walk_rsp_fault) begin
            resp_fault <= 1'b1;
            resp_paddr <= '0;
            resp_perm  <= '0;
            state_q    <= ST_RESP;
          end else begin
            state_q <= ST_LOOK;
          end
        end
        ST_RESP: if (resp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign resp_valid     = (state_q == ST_RESP);
  assign walk_req_valid = (state_q == ST_WREQ);
  assign walk_vpn       = cur_vpn_q;
  assign walk_rsp_ready = (state_q == ST_WWAIT);

  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr)
      && $stable(resp_fault) && $stable(resp_perm)); // R11
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_vpn)); // R3
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK) |-> $onehot0(match)); // R8
  AST_FAULT_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_ready && walk_rsp_fault |=> resp_valid && resp_fault); // R5
endmodule

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, resp_ready = 1'b1;
  logic [19:0] req_vpn = '0;
  logic [11:0] req_offset = '0;
  logic        req_ready, resp_valid, resp_fault;
  logic [31:0] resp_paddr;
  logic [3:0]  resp_perm;
  logic        walk_req_valid, walk_rsp_ready;
  logic        walk_req_ready = 1'b1;
  logic [19:0] walk_vpn;
  logic        walk_rsp_valid = 1'b0, walk_rsp_fault = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic [3:0]  walk_rsp_perm = '0;
  logic        flush_tb = 1'b0, flush_wk = 1'b0, flush;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;

  assign flush = flush_tb | flush_wk;
  always #5 clk = ~clk;

  tlb_cache dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .req_offset(req_offset), .req_store(req_store),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .resp_perm(resp_perm),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready), .walk_vpn(walk_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ready(walk_rsp_ready),
    .walk_rsp_fault(walk_rsp_fault), .walk_rsp_ppn(walk_rsp_ppn),
    .walk_rsp_perm(walk_rsp_perm),
    .flush(flush), .inv_valid(inv_valid), .inv_vpn(inv_vpn)
  );

  typedef struct {
    logic        fault;
    logic [31:0] paddr;
    logic [3:0]  perm;
    int          lat;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, failures = 0;
  int          cyc = 0, acc_cyc = 0, walks = 0;
  logic [19:0] cur_vpn = '0;
  logic        cur_st = 1'b0;
  logic        drop_knob = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    return v ^ 20'h5A5A5;
  endfunction

  // Walker model: faults on pages with bit 19 set; dirty flag follows the access kind.
  initial forever begin
    @(negedge clk);
    if (walk_req_valid) begin
      walks++;
      chk(walk_vpn == cur_vpn, "R3", "walk_vpn", {12'h0, walk_vpn}, {12'h0, cur_vpn});
      @(negedge clk);
      walk_rsp_valid = 1'b1;
      walk_rsp_fault = cur_vpn[19];
      walk_rsp_ppn   = ppn_of(cur_vpn);
      walk_rsp_perm  = {cur_st, 1'b1, 1'b1, cur_vpn[0]};
      flush_wk       = drop_knob;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      flush_wk       = 1'b0;
      drop_knob      = 1'b0;
    end
  end

  // Monitor: compare each response on the cycle it is taken.
  initial forever begin
    @(negedge clk);
    #1;
    if (resp_valid && resp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", resp_paddr, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(resp_fault == e.fault, e.req, "resp_fault", {31'h0, resp_fault}, {31'h0, e.fault});
        if (!e.fault) begin
          chk(resp_paddr == e.paddr, e.req, "resp_paddr", resp_paddr, e.paddr);
          chk(resp_perm == e.perm, e.req, "resp_perm", {28'h0, resp_perm}, {28'h0, e.perm});
        end
        if (e.lat >= 0)
          chk(cyc - acc_cyc == e.lat, e.req, "latency", cyc - acc_cyc, e.lat);
      end
    end
  end

  task automatic access(input logic [19:0] v, input logic [11:0] off, input bit st,
                        input bit dexp, input int nwalk, input int lat, input string req);
    exp_t e;
    int   w0;
    e.fault = v[19];
    e.paddr = {ppn_of(v), off};
    e.perm  = {dexp, 1'b1, 1'b1, v[0]};
    e.lat   = lat;
    e.req   = req;
    sb.push_back(e);
    w0 = walks;
    @(negedge clk);
    cur_vpn = v; cur_st = st;
    req_vpn = v; req_offset = off; req_store = st; req_valid = 1'b1;
    @(posedge clk);
    #1 acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(walks - w0 == nwalk, req, "walk count", walks - w0, nwalk);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_tb = 1'b1;
    @(negedge clk); flush_tb = 1'b0;
  endtask

  task automatic invalidate(input logic [19:0] v);
    @(negedge clk); inv_valid = 1'b1; inv_vpn = v;
    @(negedge clk); inv_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(req_ready == 1'b1, "R1", "req_ready", {31'h0, req_ready}, 32'h1);
    chk(resp_valid == 1'b0, "R1", "resp_valid", {31'h0, resp_valid}, 32'h0);
    chk(walk_req_valid == 1'b0, "R1", "walk_req_valid", {31'h0, walk_req_valid}, 32'h0);

    // R1/R3/R4: first touch walks, then hits in one cycle (R2)
    access(20'h12345, 12'habc, 1'b0, 1'b0, 1, -1, "R4");
    access(20'h12345, 12'h123, 1'b0, 1'b0, 0, 1, "R2");

    // R8: store to a clean entry walks; refreshed entry then hits for stores
    access(20'h12345, 12'h010, 1'b1, 1'b1, 1, -1, "R8");
    access(20'h12345, 12'h020, 1'b1, 1'b1, 0, 1, "R8");

    // R5: faulting page is never cached
    access(20'h80001, 12'h000, 1'b0, 1'b0, 1, -1, "R5");
    access(20'h80001, 12'h000, 1'b0, 1'b0, 1, -1, "R5");

    // R7: invalidate removes only the named page
    access(20'h12346, 12'h444, 1'b0, 1'b0, 1, -1, "R7");
    invalidate(20'h12345);
    access(20'h12346, 12'h444, 1'b0, 1'b0, 0, 1, "R7");
    access(20'h12345, 12'h555, 1'b0, 1'b0, 1, -1, "R7");

    // R6: flush empties everything
    pulse_flush();
    access(20'h12345, 12'h555, 1'b0, 1'b0, 1, -1, "R6");
    access(20'h12346, 12'h444, 1'b0, 1'b0, 1, -1, "R6");

    // R9: LRU within set 0
    pulse_flush();
    access(20'h00010, 12'h001, 1'b0, 1'b0, 1, -1, "R9");
    access(20'h00020, 12'h002, 1'b0, 1'b0, 1, -1, "R9");
    access(20'h00030, 12'h003, 1'b0, 1'b0, 1, -1, "R9");
    access(20'h00040, 12'h004, 1'b0, 1'b0, 1, -1, "R9");
    access(20'h00010, 12'h005, 1'b0, 1'b0, 0, 1, "R9");
    access(20'h00050, 12'h006, 1'b0, 1'b0, 1, -1, "R9");
    access(20'h00010, 12'h007, 1'b0, 1'b0, 0, 1, "R9");
    access(20'h00030, 12'h008, 1'b0, 1'b0, 0, 1, "R9");
    access(20'h00020, 12'h009, 1'b0, 1'b0, 1, -1, "R9");

    // R10: flush in the fill cycle drops the fill, retry walks again
    drop_knob = 1'b1;
    access(20'h02222, 12'h0ff, 1'b0, 1'b0, 2, -1, "R10");
    access(20'h02222, 12'h0ff, 1'b0, 1'b0, 0, 1, "R10");

    // R11: back-pressure holds the response
    begin
      exp_t e;
      logic [31:0] held;
      e.fault = 1'b0; e.paddr = {ppn_of(20'h02222), 12'h777};
      e.perm = 4'b0110; e.lat = -1; e.req = "R11";
      @(negedge clk); resp_ready = 1'b0;
      sb.push_back(e);
      @(negedge clk);
      cur_vpn = 20'h02222; cur_st = 1'b0;
      req_vpn = 20'h02222; req_offset = 12'h777; req_store = 1'b0; req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk);
      held = resp_paddr;
      repeat (3) @(negedge clk);
      chk(resp_valid == 1'b1, "R11", "resp_valid held", {31'h0, resp_valid}, 32'h1);
      chk(resp_paddr == held, "R11", "resp_paddr held", resp_paddr, held);
      chk(req_ready == 1'b0, "R11", "req_ready while busy", {31'h0, req_ready}, 32'h0);
      resp_ready = 1'b1;
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, "R11", "req_ready after take", {31'h0, req_ready}, 32'h1);
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule